// File: doc/BRIEF.md
# Attributed Text Raster Generator

This block turns a 40 by 25 character screen into a stream of 3-bit colour pixels with horizontal sync, vertical sync and blank. Each screen cell is 8 by 8 pixels. For every cell the block reads a character byte and an attribute byte from a synchronous video RAM. It then reads one glyph row from a synchronous glyph ROM and shifts that row out as eight pixels. The attribute byte gives a foreground colour and a background colour in a scrambled bit order. Its top bit extends the character code to nine bits, which selects a second bank of glyphs.

Two copies of a raster counter run eight pixel clocks apart. The leading copy drives a six-state fetch machine. The trailing copy drives the blank and sync decode. Both read ports have one cycle of latency. The gap of eight clocks between the counters covers the fetch, so the first pixel of every line comes from column 0.

Fetch machine states and transitions:
- FS_IDLE goes to FS_CHAR on a cell start inside the active area.
- FS_CHAR (character address on the bus) goes to FS_ATTR.
- FS_ATTR (character byte captured, attribute address on the bus) goes to FS_COLOR.
- FS_COLOR (attribute captured and reordered) goes to FS_GLYPH.
- FS_GLYPH (glyph address on the bus) goes to FS_LOAD.
- FS_LOAD (glyph row and colours staged) goes back to FS_IDLE.

Top module: `text_raster_top`

## Requirements
- R1: A line lasts 568 clocks and a frame lasts 312 lines. The output for display position (0,0) appears 9 rising edges after reset is released. `blank` is low exactly when x < 320 and y < 200.
- R2: While `blank` is high, `pix_rgb` is 0.
- R3: `hsync` is high for display x from 344 to 391. `vsync` is high for display lines 220 to 223. Both are active-high, and each is high only while `blank` is high.
- R4: The character byte of a cell is read at video RAM address row*40+col. Its attribute byte is read at 0x800 plus that index.
- R5: A pixel whose glyph bit is 0 shows the background colour. That colour takes red from attribute bit 1, green from bit 2 and blue from bit 0. `pix_rgb` bit 0 is red, bit 1 is green and bit 2 is blue.
- R6: A pixel whose glyph bit is 1 shows the foreground colour. That colour takes red from attribute bit 5, green from bit 6 and blue from bit 4.
- R7: The glyph ROM address is {attribute bit 7, character byte, scanline y mod 8}, a total of 12 bits.
- R8: Glyph bit 0 is the leftmost pixel of the cell and bit 7 is the rightmost.
- R9: While reset is asserted, `blank` is 1 and `pix_rgb`, `hsync` and `vsync` are 0.
- R10: Each cell is fully fetched within its 8-clock slot, character first and attribute second. All 40 columns of a line are shown, including column 39.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vram_addr | output | 12 | Video RAM read address |
| vram_rdata | input | 8 | Video RAM data, one cycle after the address |
| glyph_addr | output | 12 | Glyph ROM read address |
| glyph_data | input | 8 | Glyph ROM row, one cycle after the address |
| pix_rgb | output | 3 | Pixel colour: bit 0 red, bit 1 green, bit 2 blue |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | High outside the 320x200 active area |

## Verification
The bench goes after the seams of the raster. It checks the first and last pixel of a cell and the left and right edge of the active area. A pipeline that is off by one clock would shift every line sideways, and a design that reversed the glyph bit order would mirror each cell. It also checks column 39 and row 24: a fetch that overran its slot would lose or duplicate the last cell. The attribute data is chosen so that some cells use the second glyph bank and both colours appear. A wrong colour permutation would give the wrong colours, and a dropped code bit 8 would draw the glyphs from the wrong bank.

// File: rtl/text_raster_pkg.sv
package text_raster_pkg;

    localparam int CHAR_W   = 8;
    localparam int CELL_PX  = 8;
    localparam int SCAN_W   = 3;
    localparam int GLYPH_AW = CHAR_W + 1 + SCAN_W;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_CHAR,
        FS_ATTR,
        FS_COLOR,
        FS_GLYPH,
        FS_LOAD
    } fetch_state_e;

    // Stored attribute order to internal order: bit 7 stays, colours become RGB.
    function automatic logic [7:0] swizzle_attr(input logic [7:0] a);
        return {a[7], a[3], a[4], a[6], a[5], a[0], a[2], a[1]};
    endfunction

endpackage

// File: rtl/raster_timer.sv
module raster_timer #(
    parameter int H_TOTAL = 568,
    parameter int V_TOTAL = 312,
    parameter int H_INIT  = 0,
    parameter int V_INIT  = 0,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hpos,
    output logic [VW-1:0] vpos
);

    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos <= HW'(H_INIT);
            vpos <= VW'(V_INIT);
        end else if (hpos == H_LAST) begin
            hpos <= '0;
            vpos <= (vpos == V_LAST) ? '0 : vpos + 1'b1;
        end else begin
            hpos <= hpos + 1'b1;
        end
    end

    a_r1_h_range: assert property (@(posedge clk) disable iff (!rst_n)
        hpos <= H_LAST);
    a_r1_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos == H_LAST) |=> (hpos == '0));
    a_r1_v_range: assert property (@(posedge clk) disable iff (!rst_n)
        vpos <= V_LAST);

endmodule

// File: rtl/cell_fetch.sv
module cell_fetch
    import text_raster_pkg::*;
#(
    parameter int COLS      = 40,
    parameter int ROWS      = 25,
    parameter int ADDR_W    = 12,
    parameter int ATTR_BASE = 'h800,
    parameter int HW        = 10,
    parameter int VW        = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HW-1:0]       fh,
    input  logic [VW-1:0]       fv,
    output logic [ADDR_W-1:0]   vram_addr,
    input  logic [7:0]          vram_rdata,
    output logic [GLYPH_AW-1:0] glyph_addr,
    input  logic [7:0]          glyph_data,
    output logic                cell_load,
    output logic [7:0]          stage_glyph,
    output logic [2:0]          stage_fg,
    output logic [2:0]          stage_bg
);

    localparam logic [HW-1:0] ACT_W = HW'(COLS * CELL_PX);
    localparam logic [VW-1:0] ACT_H = VW'(ROWS * CELL_PX);
    localparam logic [ADDR_W-1:0] ATTR_OFS = ADDR_W'(ATTR_BASE);

    fetch_state_e state, nxt;

    logic              in_area;
    logic              fetch_go;
    logic [ADDR_W-1:0] cell_idx;
    logic [ADDR_W-1:0] idx_q;
    logic [SCAN_W-1:0] scan_q;
    logic [7:0]        char_q;
    logic [7:0]        attr_q;

    assign in_area   = (fh < ACT_W) && (fv < ACT_H);
    assign fetch_go  = in_area && (fh[SCAN_W-1:0] == '0);
    assign cell_load = in_area && (fh[SCAN_W-1:0] == '1);
    assign cell_idx  = ADDR_W'(int'(fv >> SCAN_W) * COLS + int'(fh >> SCAN_W));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            FS_IDLE:  nxt = fetch_go ? FS_CHAR : FS_IDLE;
            FS_CHAR:  nxt = FS_ATTR;
            FS_ATTR:  nxt = FS_COLOR;
            FS_COLOR: nxt = FS_GLYPH;
            FS_GLYPH: nxt = FS_LOAD;
            FS_LOAD:  nxt = FS_IDLE;
            default:  nxt = FS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        vram_addr  = '0;
        glyph_addr = {attr_q[7], char_q, scan_q};
        unique case (state)
            FS_CHAR: vram_addr = idx_q;
            FS_ATTR: vram_addr = idx_q + ATTR_OFS;
            default: vram_addr = '0;
        endcase
    end

    // Capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            scan_q      <= '0;
            char_q      <= '0;
            attr_q      <= '0;
            stage_glyph <= '0;
            stage_fg    <= '0;
            stage_bg    <= '0;
        end else begin
            if (fetch_go) begin
                idx_q  <= cell_idx;
                scan_q <= fv[SCAN_W-1:0];
            end
            if (state == FS_ATTR)  char_q <= vram_rdata;
            if (state == FS_COLOR) attr_q <= swizzle_attr(vram_rdata);
            if (state == FS_LOAD) begin
                stage_glyph <= glyph_data;
                stage_fg    <= attr_q[5:3];
                stage_bg    <= attr_q[2:0];
            end
        end
    end

    a_r10_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |-> (state == FS_IDLE));
    a_r10_char_then_attr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_CHAR) |=> (state == FS_ATTR));
    a_r4_attr_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_ATTR) |-> (vram_addr == ADDR_W'($past(vram_addr) + ATTR_OFS)));
    a_r7_scanline: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_GLYPH) |-> (glyph_addr[SCAN_W-1:0] == fv[SCAN_W-1:0]));

endmodule

// File: rtl/pixel_out.sv
module pixel_out (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] glyph,
    input  logic [2:0] fg,
    input  logic [2:0] bg,
    input  logic       act_in,
    input  logic       hs_in,
    input  logic       vs_in,
    output logic [2:0] pix_rgb,
    output logic       hsync,
    output logic       vsync,
    output logic       blank
);

    logic [7:0] sh;
    logic [2:0] fg_s, bg_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            fg_s <= '0;
            bg_s <= '0;
        end else if (load) begin
            sh   <= glyph;
            fg_s <= fg;
            bg_s <= bg;
        end else begin
            sh   <= sh >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_rgb <= '0;
            hsync   <= 1'b0;
            vsync   <= 1'b0;
            blank   <= 1'b1;
        end else begin
            pix_rgb <= !act_in ? 3'b000 : (sh[0] ? fg_s : bg_s);
            hsync   <= hs_in;
            vsync   <= vs_in;
            blank   <= !act_in;
        end
    end

endmodule

// File: rtl/text_raster_top.sv
module text_raster_top
    import text_raster_pkg::*;
#(
    parameter int COLS      = 40,
    parameter int ROWS      = 25,
    parameter int H_TOTAL   = 568,
    parameter int V_TOTAL   = 312,
    parameter int HS_START  = 344,
    parameter int HS_LEN    = 48,
    parameter int VS_START  = 220,
    parameter int VS_LEN    = 4,
    parameter int ADDR_W    = 12,
    parameter int ATTR_BASE = 'h800
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [ADDR_W-1:0]   vram_addr,
    input  logic [7:0]          vram_rdata,
    output logic [GLYPH_AW-1:0] glyph_addr,
    input  logic [7:0]          glyph_data,
    output logic [2:0]          pix_rgb,
    output logic                hsync,
    output logic                vsync,
    output logic                blank
);

    localparam int HW   = $clog2(H_TOTAL);
    localparam int VW   = $clog2(V_TOTAL);
    localparam int LEAD = CELL_PX;
    localparam logic [HW-1:0] ACT_W = HW'(COLS * CELL_PX);
    localparam logic [VW-1:0] ACT_H = VW'(ROWS * CELL_PX);
    localparam logic [HW-1:0] HS_A  = HW'(HS_START);
    localparam logic [HW-1:0] HS_B  = HW'(HS_START + HS_LEN);
    localparam logic [VW-1:0] VS_A  = VW'(VS_START);
    localparam logic [VW-1:0] VS_B  = VW'(VS_START + VS_LEN);

    logic [HW-1:0] fh, dh;
    logic [VW-1:0] fv, dv;
    logic          cell_load;
    logic [7:0]    stage_glyph;
    logic [2:0]    stage_fg, stage_bg;
    logic          d_act, d_hs, d_vs;

    // Fetch timing leads display timing by one cell.
    raster_timer #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_INIT(0), .V_INIT(0)) u_fetch_tmr (
        .clk(clk), .rst_n(rst_n), .hpos(fh), .vpos(fv));

    raster_timer #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
                   .H_INIT(H_TOTAL - LEAD), .V_INIT(V_TOTAL - 1)) u_disp_tmr (
        .clk(clk), .rst_n(rst_n), .hpos(dh), .vpos(dv));

    cell_fetch #(.COLS(COLS), .ROWS(ROWS), .ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE),
                 .HW(HW), .VW(VW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .fh(fh), .fv(fv),
        .vram_addr(vram_addr), .vram_rdata(vram_rdata),
        .glyph_addr(glyph_addr), .glyph_data(glyph_data),
        .cell_load(cell_load), .stage_glyph(stage_glyph),
        .stage_fg(stage_fg), .stage_bg(stage_bg));

    assign d_act = (dh < ACT_W) && (dv < ACT_H);
    assign d_hs  = (dh >= HS_A) && (dh < HS_B);
    assign d_vs  = (dv >= VS_A) && (dv < VS_B);

    pixel_out u_pix (
        .clk(clk), .rst_n(rst_n), .load(cell_load), .glyph(stage_glyph),
        .fg(stage_fg), .bg(stage_bg), .act_in(d_act), .hs_in(d_hs), .vs_in(d_vs),
        .pix_rgb(pix_rgb), .hsync(hsync), .vsync(vsync), .blank(blank));

    a_r3_hsync_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> blank);
    a_r3_vsync_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> blank);
    a_r2_black_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (pix_rgb == 3'b000));

endmodule

// File: tb/text_raster_top_test.sv
module text_raster_top_test;

    localparam int HT    = 568;
    localparam int VT    = 312;
    localparam int FRAME = HT * VT;
    localparam int NPROBE = 13;
    // Probe positions in raster order: R8 cell edges, R1 area edges, R3 sync edges, R10 last cell.
    localparam int PX [NPROBE] = '{0, 7, 8, 319, 320, 344, 391, 392, 100, 319, 0, 10, 567};
    localparam int PY [NPROBE] = '{0, 0, 0, 0,   0,   5,   5,   5,   199, 199, 200, 220, 311};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] vram_addr, glyph_addr;
    logic [7:0]  vram_rdata, glyph_data;
    logic [2:0]  pix_rgb;
    logic        hsync, vsync, blank;

    logic [7:0] vram [4096];
    logic [7:0] grom [4096];

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        vram_rdata <= vram[vram_addr];
        glyph_data <= grom[glyph_addr];
    end

    text_raster_top uut (
        .clk(clk), .rst_n(rst_n), .vram_addr(vram_addr), .vram_rdata(vram_rdata),
        .glyph_addr(glyph_addr), .glyph_data(glyph_data), .pix_rgb(pix_rgb),
        .hsync(hsync), .vsync(vsync), .blank(blank));

    function automatic logic [7:0] attr_at(input int x, input int y);
        return vram[2048 + (y / 8) * 40 + x / 8];
    endfunction

    function automatic logic gbit_at(input int x, input int y);
        logic [7:0] ch, at, g;
        ch = vram[(y / 8) * 40 + x / 8];
        at = attr_at(x, y);
        g  = grom[{at[7], ch, 3'(y % 8)}];
        return g[x % 8];
    endfunction

    // {blank, hsync, vsync, rgb}
    function automatic logic [5:0] expect_at(input int x, input int y);
        logic       bl;
        logic [7:0] at;
        logic [2:0] c;
        bl = !(x < 320 && y < 200);
        c  = 3'b000;
        if (!bl) begin
            at = attr_at(x, y);
            c  = gbit_at(x, y) ? {at[4], at[6], at[5]} : {at[0], at[2], at[1]};
        end
        return {bl, (x >= 344 && x < 392), (y >= 220 && y < 224), c};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int pi = 0;
        int e_blank = 0, e_black = 0, e_sync = 0, e_all = 0;
        int e_bg = 0, e_fg = 0, e_bank = 0, e_left = 0, e_last = 0;
        for (int i = 0; i < 4096; i++) begin
            vram[i] = 8'((i * 13 + 5) ^ (i >> 3));
            grom[i] = 8'((i * 29) ^ (i >> 5) ^ 'h5A);
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check("R9 reset outputs", {blank, hsync, vsync, pix_rgb}, 6'b100000);
        rst_n = 1'b1;
        for (int n = 1; n <= FRAME + 8; n++) begin
            int lin, x, y;
            logic [5:0] ex, ac;
            @(posedge clk);
            @(negedge clk);
            lin = (FRAME - 8 + n - 1) % FRAME;
            x = lin % HT;
            y = lin / HT;
            ex = expect_at(x, y);
            ac = {blank, hsync, vsync, pix_rgb};
            if (ac[5] != ex[5]) e_blank++;
            if (blank && pix_rgb != 3'b000) e_black++;
            if (ac[4:3] != ex[4:3]) e_sync++;
            if (!ex[5] && ac[2:0] != ex[2:0]) begin
                e_all++;
                if (gbit_at(x, y)) e_fg++; else e_bg++;
                if (attr_at(x, y) & 8'h80) e_bank++;
                if (x % 8 == 0) e_left++;
                if (x / 8 == 39) e_last++;
            end
            if (pi < NPROBE && n > 8 && x == PX[pi] && y == PY[pi]) begin
                check($sformatf("R1/R3/R8 probe x=%0d y=%0d", x, y), ac, ex);
                pi++;
            end
        end
        check("R10 all probes reached", pi, NPROBE);
        check("R1 blank window mismatches", e_blank, 0);
        check("R2 nonblack while blanked", e_black, 0);
        check("R3 sync mismatches", e_sync, 0);
        check("R4 active pixel mismatches", e_all, 0);
        check("R5 background pixel mismatches", e_bg, 0);
        check("R6 foreground pixel mismatches", e_fg, 0);
        check("R7 second bank pixel mismatches", e_bank, 0);
        check("R8 leftmost pixel mismatches", e_left, 0);
        check("R10 column 39 mismatches", e_last, 0);
        finish_run();
    end

endmodule